// File: doc/BRIEF.md
# SCSI Bus Arbitration and Target Selection Sequencer

This block wins the SCSI bus for an initiator and then selects one target. A select command starts it, with or without the attention option. It waits for the bus to go free. It then arbitrates with its own ID bit against the other devices. If it loses, it tries again. Once it wins, it puts the combined own/target ID on the data lines and moves through the SEL/BSY handshake. It then waits for the target to answer, for a bounded time.

Every bus delay is a parameter counted in clock cycles. The three interrupt flags stay set until they are cleared: function complete, disconnected and bus service. An initiator-mode flag tells the surrounding controller that it now owns a connection. The bus inputs are the lines as seen on the cable. They include whatever this block drives itself.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset, the data, BSY, SEL and ATN outputs and all four flags are zero.
- R2: A start happens only when `cmd_valid` is seen in idle with code 0x08 (select, attention) or 0x09 (select, no attention). Any other code does nothing, and so does any command given while a selection is running.
- R3: The block leaves idle only when BSY, SEL and RST are all low. It then waits T_FREE cycles. After that it drives data bit `own_id` alone and asserts BSY for T_ARB cycles.
- R4: In the last arbitration cycle, the block loses if SEL is high or if any data bit above `own_id` is set. On a loss it releases the data lines and BSY and waits for bus free again. Data bits below `own_id` do not cause a loss.
- R5: After a win, the block holds its ID and BSY for T_CLEAR+T_SETTLE cycles. It then drives bits `own_id` and `dest_id` with SEL and BSY for 2*T_SKEW cycles. After that it releases BSY and keeps SEL and the data.
- R6: ATN rises on the cycle BSY is released, and only when command bit 0 is 0. It stays high until a timeout or a disconnect.
- R7: After T_SETTLE cycles, BSY is sampled once per cycle for up to max(1, `sel_count`×1024) cycles. When BSY is seen, the block waits 2*T_SKEW cycles. It then releases SEL and the data lines, sets `irq_done` and enters initiator mode.
- R8: If BSY never appears within that window, the block sets `irq_disc`, releases SEL and ATN, and returns to idle.
- R9: After a successful selection, the first REQ from the target sets `irq_svc` and returns the block to idle.
- R10: In initiator mode, a cycle with BSY and SEL both low clears initiator mode and ATN and sets `irq_disc`.
- R11: `flag_clr` clears the three interrupt flags. A flag set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| own_id | input | 3 | Initiator bus ID, held during a command |
| dest_id | input | 3 | Target bus ID, held during a command |
| sel_count | input | 24 | Selection timeout in units of 1024 cycles |
| flag_clr | input | 1 | Clears the interrupt flags |
| bus_bsy_i | input | 1 | BSY as seen on the bus |
| bus_sel_i | input | 1 | SEL as seen on the bus |
| bus_rst_i | input | 1 | RST as seen on the bus |
| bus_req_i | input | 1 | REQ as seen on the bus |
| bus_data_i | input | 8 | Data lines as seen on the bus |
| bus_data_o | output | 8 | Data lines driven by the block |
| bus_bsy_o | output | 1 | BSY drive |
| bus_sel_o | output | 1 | SEL drive |
| bus_atn_o | output | 1 | ATN drive |
| irq_done | output | 1 | Function-complete flag |
| irq_disc | output | 1 | Disconnected flag |
| irq_svc | output | 1 | Bus-service flag |
| init_mode | output | 1 | Initiator-mode flag |

## Verification
The hardest case to reach is a lost arbitration. The competing ID bit or SEL has to be on the bus during the one cycle that ends the arbitration window. The bench models the bus as the OR of the block's drive and a simulated competitor. It raises the competitor's bit as soon as the block asserts BSY and holds it until the block lets go. This shows both the loss and the retry that follows. A harmless lower-ID bit is raised in the same way during a winning run. For the full timeout, `sel_count` is set to 1 and the bench measures the exact 1024-cycle sampling window.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

   localparam int CMD_W = 8;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_BUSW,
      SQ_FREE,
      SQ_ARB,
      SQ_WIN,
      SQ_SELON,
      SQ_SELW,
      SQ_PROBE,
      SQ_DONE,
      SQ_REQW
   } sq_state_e;

   localparam logic [CMD_W-1:0] CMD_SEL_ATN   = 8'h08;
   localparam logic [CMD_W-1:0] CMD_SEL_NOATN = 8'h09;

   function automatic logic is_select(input logic [CMD_W-1:0] code);
      return (code == CMD_SEL_ATN) || (code == CMD_SEL_NOATN);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sel_delay_timer.sv
module sel_delay_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sel_arb_cmp.sv
module sel_arb_cmp #(
   parameter int ID_W   = 3,
   parameter int DATA_W = 8
) (
   input  logic [ID_W-1:0]   own_id,
   input  logic [DATA_W-1:0] bus_data,
   output logic              higher_seen
);

   logic [DATA_W-1:0] hi_bit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [ID_W-1:0] IDX = ID_W'(i);
      assign hi_bit[i] = bus_data[i] & (own_id < IDX);
   end

   assign higher_seen = |hi_bit;

endmodule

// File: rtl/sel_timeout_ctr.sv
module sel_timeout_ctr #(
   parameter int CNT_W    = 24,
   parameter int TO_SHIFT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [CNT_W-1:0] count,
   output logic             last
);

   localparam int LW = CNT_W + TO_SHIFT;

   logic [LW-1:0] limit;
   logic [LW-1:0] cnt_q;

   if (TO_SHIFT == 0) begin : g_unscaled
      assign limit = count;
   end else begin : g_scaled
      assign limit = {count, {TO_SHIFT{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end

   assign last = (limit == '0) || (cnt_q == limit - LW'(1));

endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
   import scsi_sel_pkg::*;
#(
   parameter int ID_W     = 3,
   parameter int CNT_W    = 24,
   parameter int TO_SHIFT = 10,
   parameter int T_FREE   = 8,
   parameter int T_ARB    = 24,
   parameter int T_CLEAR  = 8,
   parameter int T_SETTLE = 4,
   parameter int T_SKEW   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [CMD_W-1:0]      cmd_code,
   input  logic [ID_W-1:0]       own_id,
   input  logic [ID_W-1:0]       dest_id,
   input  logic [CNT_W-1:0]      sel_count,
   input  logic                  flag_clr,
   input  logic                  bus_bsy_i,
   input  logic                  bus_sel_i,
   input  logic                  bus_rst_i,
   input  logic                  bus_req_i,
   input  logic [(1<<ID_W)-1:0]  bus_data_i,
   output logic [(1<<ID_W)-1:0]  bus_data_o,
   output logic                  bus_bsy_o,
   output logic                  bus_sel_o,
   output logic                  bus_atn_o,
   output logic                  irq_done,
   output logic                  irq_disc,
   output logic                  irq_svc,
   output logic                  init_mode
);

   localparam int DATA_W = 1 << ID_W;
   localparam int D_WIN  = T_CLEAR + T_SETTLE;
   localparam int D_SKW2 = 2 * T_SKEW;
   localparam int MAX_D  = imax(imax(T_FREE, T_ARB), imax(imax(D_WIN, D_SKW2), T_SETTLE));
   localparam int TMR_W  = $clog2(MAX_D + 1);

   localparam logic [TMR_W-1:0] LD_FREE   = TMR_W'(T_FREE - 1);
   localparam logic [TMR_W-1:0] LD_ARB    = TMR_W'(T_ARB - 1);
   localparam logic [TMR_W-1:0] LD_WIN    = TMR_W'(D_WIN - 1);
   localparam logic [TMR_W-1:0] LD_SKW2   = TMR_W'(D_SKW2 - 1);
   localparam logic [TMR_W-1:0] LD_SETTLE = TMR_W'(T_SETTLE - 1);

   if (T_FREE < 1 || T_ARB < 1 || T_SETTLE < 1 || T_SKEW < 1 || T_CLEAR < 0) begin : g_bad_delay
      $error("scsi_sel_seq: every bus delay must be at least one cycle");
   end
   if (ID_W < 1 || ID_W > 4) begin : g_bad_id
      $error("scsi_sel_seq: ID_W must be between 1 and 4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("scsi_sel_seq: CNT_W must be positive");
   end

   sq_state_e         state_q, state_d;
   logic              noatn_q, noatn_d;
   logic              atn_q, init_q;
   logic              done_q, disc_q, svc_q;
   logic              atn_set, atn_clr, init_set, init_clr;
   logic              set_done, set_disc, set_svc;
   logic              tmr_load, tmr_exp;
   logic [TMR_W-1:0]  tmr_val;
   logic              to_clr, to_step, to_last;
   logic              higher_seen;
   logic              bus_idle3, conn_drop;
   logic [DATA_W-1:0] own_bit, dst_bit;
   logic              drive_own, drive_dst;

   sel_delay_timer #(.W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   sel_arb_cmp #(.ID_W(ID_W), .DATA_W(DATA_W)) u_cmp (
      .own_id      (own_id),
      .bus_data    (bus_data_i),
      .higher_seen (higher_seen)
   );

   sel_timeout_ctr #(.CNT_W(CNT_W), .TO_SHIFT(TO_SHIFT)) u_to (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (to_clr),
      .step  (to_step),
      .count (sel_count),
      .last  (to_last)
   );

   assign bus_idle3 = !bus_bsy_i && !bus_sel_i && !bus_rst_i;
   assign conn_drop = init_q && !bus_bsy_i && !bus_sel_i;

   always_comb begin
      state_d  = state_q;
      noatn_d  = noatn_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      to_clr   = 1'b0;
      to_step  = 1'b0;
      set_done = 1'b0;
      set_disc = 1'b0;
      set_svc  = 1'b0;
      atn_set  = 1'b0;
      atn_clr  = 1'b0;
      init_set = 1'b0;
      init_clr = 1'b0;

      if (conn_drop) begin
         init_clr = 1'b1;
         set_disc = 1'b1;
         atn_clr  = 1'b1;
      end

      case (state_q)
         SQ_IDLE: begin
            if (cmd_valid && is_select(cmd_code)) begin
               noatn_d = cmd_code[0];
               state_d = SQ_BUSW;
            end
         end
         SQ_BUSW: begin
            if (bus_idle3) begin
               state_d  = SQ_FREE;
               tmr_load = 1'b1;
               tmr_val  = LD_FREE;
            end
         end
         SQ_FREE: begin
            if (tmr_exp) begin
               state_d  = SQ_ARB;
               tmr_load = 1'b1;
               tmr_val  = LD_ARB;
            end
         end
         SQ_ARB: begin
            if (tmr_exp) begin
               if (bus_sel_i || higher_seen) begin
                  state_d = SQ_BUSW;
               end else begin
                  state_d  = SQ_WIN;
                  tmr_load = 1'b1;
                  tmr_val  = LD_WIN;
               end
            end
         end
         SQ_WIN: begin
            if (tmr_exp) begin
               state_d  = SQ_SELON;
               tmr_load = 1'b1;
               tmr_val  = LD_SKW2;
            end
         end
         SQ_SELON: begin
            if (tmr_exp) begin
               state_d  = SQ_SELW;
               tmr_load = 1'b1;
               tmr_val  = LD_SETTLE;
               atn_set  = !noatn_q;
            end
         end
         SQ_SELW: begin
            if (tmr_exp) begin
               state_d = SQ_PROBE;
               to_clr  = 1'b1;
            end
         end
         SQ_PROBE: begin
            if (bus_bsy_i) begin
               state_d  = SQ_DONE;
               tmr_load = 1'b1;
               tmr_val  = LD_SKW2;
            end else if (to_last) begin
               state_d  = SQ_IDLE;
               set_disc = 1'b1;
               atn_clr  = 1'b1;
            end else begin
               to_step = 1'b1;
            end
         end
         SQ_DONE: begin
            if (tmr_exp) begin
               state_d  = SQ_REQW;
               set_done = 1'b1;
               init_set = 1'b1;
            end
         end
         SQ_REQW: begin
            if (conn_drop) begin
               state_d = SQ_IDLE;
            end else if (bus_req_i) begin
               state_d = SQ_IDLE;
               set_svc = 1'b1;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         noatn_q <= 1'b0;
         atn_q   <= 1'b0;
         init_q  <= 1'b0;
         done_q  <= 1'b0;
         disc_q  <= 1'b0;
         svc_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         noatn_q <= noatn_d;
         if (atn_set)
            atn_q <= 1'b1;
         else if (atn_clr)
            atn_q <= 1'b0;
         if (init_set)
            init_q <= 1'b1;
         else if (init_clr)
            init_q <= 1'b0;
         done_q <= (done_q & ~flag_clr) | set_done;
         disc_q <= (disc_q & ~flag_clr) | set_disc;
         svc_q  <= (svc_q & ~flag_clr) | set_svc;
      end
   end

   assign own_bit   = DATA_W'(1) << own_id;
   assign dst_bit   = DATA_W'(1) << dest_id;
   assign drive_own = (state_q == SQ_ARB) || (state_q == SQ_WIN) || drive_dst;
   assign drive_dst = (state_q == SQ_SELON) || (state_q == SQ_SELW) ||
                      (state_q == SQ_PROBE) || (state_q == SQ_DONE);

   assign bus_data_o = (drive_own ? own_bit : '0) | (drive_dst ? dst_bit : '0);
   assign bus_bsy_o  = (state_q == SQ_ARB) || (state_q == SQ_WIN) || (state_q == SQ_SELON);
   assign bus_sel_o  = drive_dst;
   assign bus_atn_o  = atn_q;
   assign irq_done   = done_q;
   assign irq_disc   = disc_q;
   assign irq_svc    = svc_q;
   assign init_mode  = init_q;

endmodule

// File: rtl/scsi_sel_seq_chk.sv
module scsi_sel_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_bsy_i,
   input logic              bus_sel_i,
   input logic [DATA_W-1:0] bus_data_o,
   input logic              bus_bsy_o,
   input logic              bus_sel_o,
   input logic              bus_atn_o,
   input logic              irq_done,
   input logic              irq_disc,
   input logic              irq_svc,
   input logic              init_mode
);

   AST_ARB_SINGLE_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_bsy_o && !bus_sel_o) |-> ($onehot0(bus_data_o) && bus_data_o != '0)); // R3

   AST_SEL_WITH_BSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_sel_o) |-> bus_bsy_o); // R5

   AST_ATN_AFTER_BSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_atn_o) |-> (bus_sel_o && !bus_bsy_o)); // R6

   AST_DONE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_done) |-> (init_mode && !bus_sel_o && bus_data_o == '0)); // R7

   AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_disc) && !$past(init_mode)) |-> (!bus_sel_o && !bus_atn_o)); // R8

   AST_SVC_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_svc) |-> $past(init_mode)); // R9

   AST_DROP_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (init_mode && !bus_bsy_i && !bus_sel_i) |=> (!init_mode && irq_disc && !bus_atn_o)); // R10

endmodule

bind scsi_sel_seq scsi_sel_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_bsy_i  (bus_bsy_i),
   .bus_sel_i  (bus_sel_i),
   .bus_data_o (bus_data_o),
   .bus_bsy_o  (bus_bsy_o),
   .bus_sel_o  (bus_sel_o),
   .bus_atn_o  (bus_atn_o),
   .irq_done   (irq_done),
   .irq_disc   (irq_disc),
   .irq_svc    (irq_svc),
   .init_mode  (init_mode)
);

// File: tb/scsi_sel_seq_tb_top.sv
module scsi_sel_seq_tb_top;

   localparam int T_FREE   = 8;
   localparam int T_ARB    = 24;
   localparam int T_CLEAR  = 8;
   localparam int T_SETTLE = 4;
   localparam int T_SKEW   = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = 8'h00;
   logic [2:0]  own_id = 3'd5;
   logic [2:0]  dest_id = 3'd2;
   logic [23:0] sel_count = 24'd1;
   logic        flag_clr = 1'b0;
   logic        oth_bsy = 1'b0, oth_sel = 1'b0, oth_rst = 1'b0, oth_req = 1'b0;
   logic [7:0]  oth_data = 8'h00;

   logic [7:0]  bus_data_o;
   logic        bus_bsy_o, bus_sel_o, bus_atn_o;
   logic        irq_done, irq_disc, irq_svc, init_mode;
   logic        bus_bsy_i, bus_sel_i;
   logic [7:0]  bus_data_i;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   assign bus_bsy_i  = bus_bsy_o | oth_bsy;
   assign bus_sel_i  = bus_sel_o | oth_sel;
   assign bus_data_i = bus_data_o | oth_data;

   scsi_sel_seq #(
      .T_FREE(T_FREE), .T_ARB(T_ARB), .T_CLEAR(T_CLEAR),
      .T_SETTLE(T_SETTLE), .T_SKEW(T_SKEW)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code),
      .own_id     (own_id),
      .dest_id    (dest_id),
      .sel_count  (sel_count),
      .flag_clr   (flag_clr),
      .bus_bsy_i  (bus_bsy_i),
      .bus_sel_i  (bus_sel_i),
      .bus_rst_i  (oth_rst),
      .bus_req_i  (oth_req),
      .bus_data_i (bus_data_i),
      .bus_data_o (bus_data_o),
      .bus_bsy_o  (bus_bsy_o),
      .bus_sel_o  (bus_sel_o),
      .bus_atn_o  (bus_atn_o),
      .irq_done   (irq_done),
      .irq_disc   (irq_disc),
      .irq_svc    (irq_svc),
      .init_mode  (init_mode)
   );

   // behavioural reference: phase numbers 0 idle, 1 wait free, 2 free delay,
   // 3 arbitrate, 4 won, 5 SEL+BSY, 6 settle, 7 probe, 8 hold, 9 wait REQ
   int     m_ph, m_rem;
   longint m_probes;
   bit     m_noatn, m_atn, m_init, m_done, m_disc, m_svc;

   function automatic longint win_limit(input logic [23:0] c);
      longint l;
      l = longint'(c) * 1024;
      return (l == 0) ? 1 : l;
   endfunction

   function automatic bit above_own(input logic [7:0] d, input logic [2:0] o);
      for (int i = 0; i < 8; i++)
         if (d[i] && i > int'(o)) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_rem = 0; m_probes = 0;
         m_noatn = 0; m_atn = 0; m_init = 0;
         m_done = 0; m_disc = 0; m_svc = 0;
      end else begin
         bit drop;
         drop = m_init && !bus_bsy_i && !bus_sel_i;
         if (flag_clr) begin m_done = 0; m_disc = 0; m_svc = 0; end
         if (drop) begin m_init = 0; m_disc = 1; m_atn = 0; end
         case (m_ph)
            0: if (cmd_valid && (cmd_code == 8'h08 || cmd_code == 8'h09)) begin
                  m_noatn = cmd_code[0]; m_ph = 1;
               end
            1: if (!bus_bsy_i && !bus_sel_i && !oth_rst) begin m_ph = 2; m_rem = T_FREE; end
            2: if (m_rem == 1) begin m_ph = 3; m_rem = T_ARB; end else m_rem--;
            3: if (m_rem == 1) begin
                  if (bus_sel_i || above_own(bus_data_i, own_id)) m_ph = 1;
                  else begin m_ph = 4; m_rem = T_CLEAR + T_SETTLE; end
               end else m_rem--;
            4: if (m_rem == 1) begin m_ph = 5; m_rem = 2 * T_SKEW; end else m_rem--;
            5: if (m_rem == 1) begin m_ph = 6; m_rem = T_SETTLE; m_atn = !m_noatn; end else m_rem--;
            6: if (m_rem == 1) begin m_ph = 7; m_probes = 0; end else m_rem--;
            7: if (bus_bsy_i) begin m_ph = 8; m_rem = 2 * T_SKEW; end
               else begin
                  m_probes++;
                  if (m_probes >= win_limit(sel_count)) begin m_ph = 0; m_disc = 1; m_atn = 0; end
               end
            8: if (m_rem == 1) begin m_ph = 9; m_done = 1; m_init = 1; end else m_rem--;
            9: if (drop) m_ph = 0;
               else if (oth_req) begin m_svc = 1; m_ph = 0; end
            default: m_ph = 0;
         endcase
      end
   end

   task automatic cmp1(input string req, input string nm, input logic a, input logic e, inout bit bad);
      if (a !== e) begin
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, a, e, $time);
         bad = 1'b1;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit bad;
         logic [7:0] e_data;
         bad = 1'b0;
         e_data = ((m_ph >= 3 && m_ph <= 8) ? (8'h01 << own_id) : 8'h00) |
                  ((m_ph >= 5 && m_ph <= 8) ? (8'h01 << dest_id) : 8'h00);
         vectors++;
         if (bus_data_o !== e_data) begin
            $display("FAIL R3 data actual=%02h expected=%02h t=%0t", bus_data_o, e_data, $time);
            bad = 1'b1;
         end
         cmp1("R3", "bsy", bus_bsy_o, (m_ph >= 3 && m_ph <= 5), bad);
         cmp1("R5", "sel", bus_sel_o, (m_ph >= 5 && m_ph <= 8), bad);
         cmp1("R6", "atn", bus_atn_o, m_atn, bad);
         cmp1("R7", "irq_done", irq_done, m_done, bad);
         cmp1("R7", "init_mode", init_mode, m_init, bad);
         cmp1("R8", "irq_disc", irq_disc, m_disc, bad);
         cmp1("R9", "irq_svc", irq_svc, m_svc, bad);
         if (bad) miscompares++;
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp_v);
      vectors++;
      if (act != exp_v) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
      end
   endtask

   task automatic issue(input logic [7:0] code);
      cmd_code  = code;
      cmd_valid = 1'b1;
      step();
      cmd_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      step();
      flag_clr = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk("R1 data", int'(bus_data_o), 0);
      chk("R1 bsy/sel/atn", int'({bus_bsy_o, bus_sel_o, bus_atn_o}), 0);
      chk("R1 flags", int'({irq_done, irq_disc, irq_svc, init_mode}), 0);

      // R2: a non-select code is ignored
      issue(8'h0B);
      repeat (40) step();
      chk("R2 bsy after bad code", int'(bus_bsy_o), 0);

      // Scenario A: own 5, target 2, select with attention
      own_id = 3'd5; dest_id = 3'd2; sel_count = 24'd1;
      oth_bsy = 1'b1;
      issue(8'h08);
      repeat (30) step();
      chk("R3 waits while BSY busy", int'(bus_bsy_o), 0);
      oth_bsy = 1'b0;
      n = 0;
      while (!bus_bsy_o && n < 200) begin step(); n++; end
      chk("R3 free delay cycles", n, T_FREE + 1);
      chk("R3 own bit only", int'(bus_data_o), 8'h20);
      oth_data = 8'h02;
      n = 0;
      while (!bus_sel_o && n < 200) begin step(); n++; end
      oth_data = 8'h00;
      chk("R4 lower id does not win", int'(bus_sel_o), 1);
      chk("R5 own and target bits", int'(bus_data_o), 8'h24);
      n = 0;
      while (bus_bsy_o && n < 50) begin step(); n++; end
      chk("R6 atn with bsy release", int'(bus_atn_o), 1);
      chk("R5 sel held", int'(bus_sel_o), 1);
      issue(8'h09);
      repeat (2) step();
      oth_bsy = 1'b1;
      n = 0;
      while (!irq_done && n < 200) begin step(); n++; end
      chk("R7 initiator mode", int'(init_mode), 1);
      chk("R7 sel and data released", int'({bus_sel_o, bus_data_o}), 0);
      chk("R2 busy command ignored", int'(bus_bsy_o), 0);
      repeat (5) step();
      chk("R9 no service before REQ", int'(irq_svc), 0);
      oth_req = 1'b1;
      step();
      oth_req = 1'b0;
      chk("R9 service flag", int'(irq_svc), 1);
      pulse_clr();
      chk("R11 flags cleared", int'({irq_done, irq_svc}), 0);
      chk("R10 still connected", int'(init_mode), 1);
      oth_bsy = 1'b0;
      step();
      chk("R10 mode cleared", int'(init_mode), 0);
      chk("R10 disconnect flag", int'(irq_disc), 1);
      chk("R10 atn dropped", int'(bus_atn_o), 0);
      pulse_clr();

      // Scenario B: lose to a higher id, retry, short timeout without attention
      own_id = 3'd2; dest_id = 3'd6; sel_count = 24'd0;
      issue(8'h09);
      n = 0;
      while (!bus_bsy_o && n < 200) begin step(); n++; end
      oth_data = 8'h80;
      n = 0;
      while (bus_bsy_o && n < 200) begin step(); n++; end
      chk("R4 lost to higher id", int'({bus_data_o, bus_sel_o}), 0);
      oth_data = 8'h00;
      n = 0;
      while (!bus_bsy_o && n < 200) begin step(); n++; end
      chk("R4 retries arbitration", int'(bus_bsy_o), 1);
      n = 0;
      while (!irq_disc && n < 300) begin step(); n++; end
      chk("R8 timeout flag", int'(irq_disc), 1);
      chk("R6 no atn without attention", int'(bus_atn_o), 0);
      chk("R8 released", int'({bus_sel_o, init_mode}), 0);
      pulse_clr();

      // Scenario C: RST blocks start, SEL during arbitration, full timeout
      own_id = 3'd3; dest_id = 3'd0; sel_count = 24'd1;
      oth_rst = 1'b1;
      issue(8'h08);
      repeat (20) step();
      chk("R3 waits while RST", int'(bus_bsy_o), 0);
      oth_rst = 1'b0;
      n = 0;
      while (!bus_bsy_o && n < 200) begin step(); n++; end
      oth_sel = 1'b1;
      n = 0;
      while (bus_bsy_o && n < 200) begin step(); n++; end
      chk("R4 lost to SEL", int'(bus_sel_o), 0);
      oth_sel = 1'b0;
      n = 0;
      while (!bus_atn_o && n < 300) begin step(); n++; end
      n = 0;
      while (!irq_disc && n < 3000) begin step(); n++; end
      chk("R8 window length", n, T_SETTLE + 1024);
      chk("R8 atn and sel released", int'({bus_atn_o, bus_sel_o}), 0);
      repeat (5) step();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule